// File: doc/BRIEF.md
# Register Window Pointer Manager

This block keeps the current window pointer for a windowed register file holding 128, 256 or 512 registers, of which 32 are visible to software at any moment. Each window is 16 registers wide, so the file has 8, 16 or 32 windows. A call-style SAVE command opens a fresh window by stepping the pointer down by one. A RESTORE command steps it back up by one. An accepted exception or trap opens a window in the same way as a SAVE. Software may also write the pointer directly.

Every SAVE, trap and RESTORE is checked against a low and a high limit held in a programmable window-valid register. If the step would take the pointer outside those limits, the pointer holds its value and the block requests a window exception, so that handler software can spill or fill registers to memory. A direct write is never checked.

The block also translates a 5-bit architectural register index into a physical register address. Indices 0 to 7 select the shared globals. The out and local groups come from the current window, and the in group aliases the out group of the caller's window. A build-time flat option freezes the pointer and turns both checks off.

Top module: `regwin_ptr_mgr`

## Requirements
- R1: After reset the pointer equals NUM_WIN-1, the low limit is 0, the high limit is NUM_WIN-1, and no exception is requested.
- R2: A SAVE whose new value (pointer-1, evaluated as a signed number) is not below the low limit and not above the high limit sets the pointer to pointer-1 at the next clock edge.
- R3: A RESTORE whose new value (pointer+1) is within the limits sets the pointer to pointer+1 at the next clock edge.
- R4: A RESTORE or SAVE whose new value is above the high limit leaves the pointer unchanged. For exactly one cycle after that edge, exc_req is 1 and exc_num is 2 (overflow).
- R5: A SAVE, trap or RESTORE whose new value is below the low limit leaves the pointer unchanged. For exactly one cycle after that edge, exc_req is 1 and exc_num is 1 (underflow). When both limits are violated, underflow is reported.
- R6: A direct pointer write loads ptr_wdata at the next edge and never raises exc_req, even when the value lies outside the limits.
- R7: A trap-entry pulse opens a window exactly as a SAVE does: it decrements the pointer and is subject to the same checks.
- R8: When several commands arrive in one cycle, the direct write wins over the trap, the trap over SAVE, and SAVE over RESTORE. The losing commands have no effect.
- R9: phys_addr (combinational, with p the pointer and W = NUM_WIN) is computed as follows. For index i < 8 it is i. For 8 <= i < 24 it is 16p + i. For i >= 24 it is 16*((p+1) mod W) + i - 16.
- R10: A limit write (lim_wr_en) loads lim_lo and lim_hi at the next edge. A command issued in the same cycle is checked against the old limits.
- R11: With FLAT=1 the pointer stays at NUM_WIN-1 whatever the commands, and exc_req is never raised.

Window exceptions can be requested every cycle, and the block has no handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_wr | input | 1 | Direct pointer write strobe |
| ptr_wdata | input | PTR_W | Value for a direct pointer write |
| trap_enter | input | 1 | Accepted exception or trap opens a window |
| cmd_save | input | 1 | SAVE command |
| cmd_restore | input | 1 | RESTORE command |
| lim_wr_en | input | 1 | Window-valid register write strobe |
| lim_lo | input | PTR_W | New low limit |
| lim_hi | input | PTR_W | New high limit |
| arch_idx | input | 5 | Architectural register index |
| cwp | output | PTR_W | Current window pointer |
| phys_addr | output | PHYS_W | Physical register address for arch_idx |
| exc_req | output | 1 | One-cycle window exception request |
| exc_num | output | 6 | Exception number (1 underflow, 2 overflow) |

## Verification
The hardest situations to reach are a step that crosses a limit, and a step that lands exactly on a limit. With random SAVE and RESTORE alone, the pointer drifts and seldom sits next to a narrow window of limits. The stimulus therefore reprograms the limits often, and uses direct writes to park the pointer on, just inside or just outside a limit before issuing steps. Directed cases cover pointer zero with a SAVE, the top window with a RESTORE, and a pointer left below the low limit by a write, where even a RESTORE is refused as an underflow.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LOAD = 2'd1,
    OP_DOWN = 2'd2,
    OP_UP   = 2'd3
  } win_op_e;

  localparam logic [5:0] EXC_NONE  = 6'd0;
  localparam logic [5:0] EXC_UNDER = 6'd1;
  localparam logic [5:0] EXC_OVER  = 6'd2;

  // Exception number for a candidate pointer value; underflow is tested first.
  function automatic logic [5:0] win_check(input int nxt, input int lo, input int hi);
    if (nxt < lo)      return EXC_UNDER;
    else if (nxt > hi) return EXC_OVER;
    else               return EXC_NONE;
  endfunction

  // Architectural index to physical address.
  function automatic int phys_of(input int ptr, input int idx, input int nwin);
    int caller;
    caller = (ptr + 1) % nwin;
    if (idx < 8)       return idx;
    else if (idx < 24) return ptr * 16 + idx;
    else               return caller * 16 + idx - 16;
  endfunction

endpackage

// File: rtl/regwin_limits.sv
module regwin_limits #(
  parameter int NUM_WIN = 32,
  parameter int PTR_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] lo_in,
  input  logic [PTR_W-1:0] hi_in,
  output logic [PTR_W-1:0] lo_q,
  output logic [PTR_W-1:0] hi_q
);
  localparam logic [PTR_W-1:0] TOP = PTR_W'(NUM_WIN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= TOP;
    end else if (wr_en) begin
      lo_q <= lo_in;
      hi_q <= hi_in;
    end
  end

  // R10: limits take the written value at the next edge
  a_r10_limit_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (lo_q == $past(lo_in)) && (hi_q == $past(hi_in)));

  a_r10_limit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(lo_q) && $stable(hi_q));
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int NUM_WIN = 32,
  parameter int PTR_W   = 5,
  parameter bit FLAT    = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_wr,
  input  logic [PTR_W-1:0] ptr_wdata,
  input  logic             trap_enter,
  input  logic             cmd_save,
  input  logic             cmd_restore,
  input  logic [PTR_W-1:0] lo_q,
  input  logic [PTR_W-1:0] hi_q,
  output logic [PTR_W-1:0] cwp,
  output logic             exc_req,
  output logic [5:0]       exc_num
);
  localparam logic [PTR_W-1:0] TOP = PTR_W'(NUM_WIN - 1);

  win_op_e    op;
  int         nxt;
  logic [5:0] code;
  // Named events for the assertions
  logic       load_evt;
  logic       step_ok;
  logic       over_evt;
  logic       under_evt;

  // R8: direct write > trap > save > restore
  always_comb begin
    if (ptr_wr)                     op = OP_LOAD;
    else if (trap_enter || cmd_save) op = OP_DOWN;
    else if (cmd_restore)           op = OP_UP;
    else                            op = OP_IDLE;
  end

  always_comb begin
    nxt  = (op == OP_UP) ? int'(cwp) + 1 : int'(cwp) - 1;
    code = win_check(nxt, int'(lo_q), int'(hi_q));
  end

  assign load_evt  = !FLAT && (op == OP_LOAD);
  assign step_ok   = !FLAT && (op == OP_DOWN || op == OP_UP) && (code == EXC_NONE);
  assign over_evt  = !FLAT && (op == OP_DOWN || op == OP_UP) && (code == EXC_OVER);
  assign under_evt = !FLAT && (op == OP_DOWN || op == OP_UP) && (code == EXC_UNDER);

  generate
    if (FLAT) begin : g_flat
      assign cwp     = TOP;
      assign exc_req = 1'b0;
      assign exc_num = EXC_NONE;

      // R11: flat build keeps the pointer and never faults
      a_r11_flat_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_save || cmd_restore || trap_enter || ptr_wr) |=> (cwp == TOP) && !exc_req);
    end else begin : g_win
      logic [PTR_W-1:0] ptr_q;
      logic             req_q;
      logic [5:0]       num_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ptr_q <= TOP;
          req_q <= 1'b0;
          num_q <= EXC_NONE;
        end else begin
          req_q <= over_evt || under_evt;
          num_q <= (over_evt || under_evt) ? code : EXC_NONE;
          if (load_evt)     ptr_q <= ptr_wdata;
          else if (step_ok) ptr_q <= PTR_W'(nxt);
        end
      end

      assign cwp     = ptr_q;
      assign exc_req = req_q;
      assign exc_num = num_q;

      // R2 and R7: an accepted SAVE or trap moves the pointer down by one
      a_r2_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok && op == OP_DOWN) |=> (cwp == $past(cwp) - 1'b1) && !exc_req);

      // R3: an accepted RESTORE moves the pointer up by one
      a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok && op == OP_UP) |=> (cwp == $past(cwp) + 1'b1) && !exc_req);

      // R4: overflow holds the pointer and requests exception 2
      a_r4_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        over_evt |=> $stable(cwp) && exc_req && (exc_num == 6'd2));

      // R5: underflow holds the pointer and requests exception 1
      a_r5_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        under_evt |=> $stable(cwp) && exc_req && (exc_num == 6'd1));

      // R6: a direct write loads the value and raises nothing
      a_r6_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr |=> (cwp == $past(ptr_wdata)) && !exc_req);

      // R8: a direct write overrides steps issued in the same cycle
      a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr && (cmd_save || cmd_restore || trap_enter)) |=> cwp == $past(ptr_wdata));

      // R4 and R5: a request lasts one cycle unless a new fault follows
      a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !over_evt && !under_evt) |=> !exc_req);
    end
  endgenerate
endmodule

// File: rtl/regwin_map.sv
module regwin_map
  import regwin_pkg::*;
#(
  parameter int NUM_WIN = 32,
  parameter int PTR_W   = 5,
  parameter int PHYS_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PTR_W-1:0]  cwp,
  input  logic [4:0]        arch_idx,
  output logic [PHYS_W-1:0] phys_addr
);
  always_comb
    phys_addr = PHYS_W'(phys_of(int'(cwp), int'(arch_idx), NUM_WIN));

  // R9: globals are shared by every window
  a_r9_globals: assert property (@(posedge clk) disable iff (!rst_n)
    (arch_idx < 5'd8) |-> (phys_addr == PHYS_W'(arch_idx)));

  // R9: the out group lies inside the current window's 16-register slice
  a_r9_out_slice: assert property (@(posedge clk) disable iff (!rst_n)
    (arch_idx >= 5'd8 && arch_idx < 5'd16) |-> (phys_addr[PHYS_W-1:4] == PHYS_W'(cwp)));
endmodule

// File: rtl/regwin_ptr_mgr.sv
module regwin_ptr_mgr #(
  parameter int NUM_REGS = 512,
  parameter bit FLAT     = 1'b0,
  parameter int NUM_WIN  = NUM_REGS / 16,
  parameter int PTR_W    = $clog2(NUM_WIN),
  parameter int PHYS_W   = $clog2(NUM_REGS + 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_wr,
  input  logic [PTR_W-1:0]  ptr_wdata,
  input  logic              trap_enter,
  input  logic              cmd_save,
  input  logic              cmd_restore,
  input  logic              lim_wr_en,
  input  logic [PTR_W-1:0]  lim_lo,
  input  logic [PTR_W-1:0]  lim_hi,
  input  logic [4:0]        arch_idx,
  output logic [PTR_W-1:0]  cwp,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              exc_req,
  output logic [5:0]        exc_num
);
  logic [PTR_W-1:0] lo_q;
  logic [PTR_W-1:0] hi_q;

  regwin_limits #(.NUM_WIN(NUM_WIN), .PTR_W(PTR_W)) u_limits (
    .clk(clk), .rst_n(rst_n), .wr_en(lim_wr_en),
    .lo_in(lim_lo), .hi_in(lim_hi), .lo_q(lo_q), .hi_q(hi_q)
  );

  regwin_ctrl #(.NUM_WIN(NUM_WIN), .PTR_W(PTR_W), .FLAT(FLAT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
    .trap_enter(trap_enter), .cmd_save(cmd_save), .cmd_restore(cmd_restore),
    .lo_q(lo_q), .hi_q(hi_q), .cwp(cwp), .exc_req(exc_req), .exc_num(exc_num)
  );

  regwin_map #(.NUM_WIN(NUM_WIN), .PTR_W(PTR_W), .PHYS_W(PHYS_W)) u_map (
    .clk(clk), .rst_n(rst_n), .cwp(cwp), .arch_idx(arch_idx), .phys_addr(phys_addr)
  );

  // R1: reset leaves the top window selected and no request pending
  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (cwp == PTR_W'(NUM_WIN - 1)) && !exc_req);
endmodule

// File: tb/tb_regwin_ptr_mgr.sv
module tb_regwin_ptr_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int NREGS  = 512;
  localparam int W      = NREGS / 16;
  localparam int PW     = $clog2(W);
  localparam int PHW    = $clog2(NREGS + 8);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ptr_wr = 0, trap_enter = 0, cmd_save = 0, cmd_restore = 0, lim_wr_en = 0;
  logic [PW-1:0] ptr_wdata = '0, lim_lo = '0, lim_hi = '0;
  logic [4:0] arch_idx = '0;
  logic [PW-1:0] cwp, cwp_f;
  logic [PHW-1:0] phys_addr, phys_f;
  logic exc_req, exc_req_f;
  logic [5:0] exc_num, exc_num_f;

  int checks = 0, errors = 0;
  bit done = 0;
  int e_ptr, e_lo, e_hi, e_num;
  bit e_req;
  string tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  regwin_ptr_mgr #(.NUM_REGS(NREGS)) dut (
    .clk, .rst_n, .ptr_wr, .ptr_wdata, .trap_enter, .cmd_save, .cmd_restore,
    .lim_wr_en, .lim_lo, .lim_hi, .arch_idx, .cwp, .phys_addr, .exc_req, .exc_num);

  regwin_ptr_mgr #(.NUM_REGS(NREGS), .FLAT(1'b1)) dut_flat (
    .clk, .rst_n, .ptr_wr, .ptr_wdata, .trap_enter, .cmd_save, .cmd_restore,
    .lim_wr_en, .lim_lo, .lim_hi, .arch_idx, .cwp(cwp_f), .phys_addr(phys_f),
    .exc_req(exc_req_f), .exc_num(exc_num_f));

  function automatic int exp_phys(int p, int i);
    if (i <= 7) return i;
    if (i >= 24) return 8 + 16 * ((p == W - 1) ? 0 : p + 1) + (i - 24);
    return 8 + 16 * p + (i - 8);
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // One cycle: check mapping, drive commands, update model, check state after the edge.
  task automatic cycle(bit wr, int wd, bit tr, bit sv, bit rs, bit lw, int lo, int hi, int idx);
    int n;
    int cnt;
    arch_idx = 5'(idx);
    #1;
    chk("R9", int'(phys_addr), exp_phys(e_ptr, idx), "phys_addr");
    ptr_wr = wr; ptr_wdata = PW'(wd); trap_enter = tr; cmd_save = sv;
    cmd_restore = rs; lim_wr_en = lw; lim_lo = PW'(lo); lim_hi = PW'(hi);
    cnt = int'(wr) + int'(tr) + int'(sv) + int'(rs);
    e_req = 0; e_num = 0;
    if (wr) begin
      e_ptr = wd; tag = (cnt > 1) ? "R8" : "R6";
    end else if (tr || sv) begin
      n = e_ptr - 1;
      if (n < e_lo) begin e_req = 1; e_num = 1; tag = "R5"; end
      else if (n > e_hi) begin e_req = 1; e_num = 2; tag = "R4"; end
      else begin e_ptr = n; tag = tr ? "R7" : ((cnt > 1) ? "R8" : "R2"); end
    end else if (rs) begin
      n = e_ptr + 1;
      if (n < e_lo) begin e_req = 1; e_num = 1; tag = "R5"; end
      else if (n > e_hi) begin e_req = 1; e_num = 2; tag = "R4"; end
      else begin e_ptr = n; tag = "R3"; end
    end else tag = lw ? "R10" : "R1";
    if (lw) begin e_lo = lo; e_hi = hi; end
    @(negedge clk);
    chk(tag, int'(cwp), e_ptr, "cwp");
    chk(tag, int'(exc_req), int'(e_req), "exc_req");
    chk(tag, int'(exc_num), e_num, "exc_num");
    chk("R11", int'(cwp_f), W - 1, "flat cwp");
    chk("R11", int'(exc_req_f), 0, "flat exc_req");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    e_ptr = W - 1; e_lo = 0; e_hi = W - 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(cwp), W - 1, "reset cwp");
    chk("R1", int'(exc_req), 0, "reset exc_req");
    // R4: restore from the top window overflows
    cycle(0, 0, 0, 0, 1, 0, 0, 0, 24);
    // R2: save from the top
    cycle(0, 0, 0, 1, 0, 0, 0, 0, 12);
    // R6: park at zero, then R5 save underflows
    cycle(1, 0, 0, 0, 0, 0, 0, 0, 30);
    cycle(0, 0, 0, 1, 0, 0, 0, 0, 3);
    // R7: trap underflows at zero too
    cycle(0, 0, 1, 0, 0, 0, 0, 0, 31);
    // R10: new limits with a same-cycle restore checked against old limits (R3)
    cycle(0, 0, 0, 0, 1, 1, 4, 10, 16);
    // R6: write outside limits, quiet; R5: restore to 3 < 4 underflows
    cycle(1, 2, 0, 0, 0, 0, 0, 0, 9);
    cycle(0, 0, 0, 0, 1, 0, 0, 0, 25);
    // edge of window: 10 then restore overflows (R4), 4 then save underflows (R5)
    cycle(1, 10, 0, 0, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 1, 0, 0, 0, 7);
    cycle(1, 5, 0, 0, 0, 0, 0, 0, 8);
    cycle(0, 0, 0, 1, 0, 0, 0, 0, 23);
    cycle(0, 0, 0, 1, 0, 0, 0, 0, 24);
    // R8: all commands together, write wins; then trap beats restore
    cycle(1, 7, 1, 1, 1, 0, 0, 0, 15);
    cycle(0, 0, 1, 0, 1, 0, 0, 0, 26);
    // constrained random with frequent limit changes and parking writes
    for (int k = 0; k < 4000; k++) begin
      int lo, hi, r, wd;
      r  = $urandom_range(0, 99);
      lo = $urandom_range(0, W - 1);
      hi = $urandom_range(lo, W - 1);
      wd = ($urandom_range(0, 1) == 1) ? (($urandom_range(0, 1) == 1) ? e_lo : e_hi)
                                       : $urandom_range(0, W - 1);
      cycle(r < 12, wd, (r >= 12 && r < 20) || r == 99, (r >= 20 && r < 55) || r == 98,
            r >= 55 || r == 97, $urandom_range(0, 19) == 0, lo, hi, $urandom_range(0, 31));
    end
    ptr_wr = 0; trap_enter = 0; cmd_save = 0; cmd_restore = 0; lim_wr_en = 0;
    finish_run();
  end
endmodule